// File: doc/BRIEF.md
# Status Flags Register Unit

This block keeps a 64-bit processor status register and carries out the operations that read and change it outside of ordinary arithmetic. It sets, clears or inverts the carry flag, and it sets or clears the direction and interrupt-enable flags. It moves five arithmetic status flags to or from an 8-bit byte image. It forms the stack image of the register at 16, 32 or 64 bits. It writes a popped value back, masked bit by bit according to the pop width, the current privilege level and the register's own I/O privilege field.

Operations arrive on a valid/ready input. `op_ready` is tied high, so the block never applies back-pressure: each cycle with `op_valid` high is one accepted operation, and it completes at that clock edge. Read results leave on `rd_valid`/`rd_data`, a one-cycle pulse with no ready. The consumer must take the pulse in the cycle it appears. The register value is visible at all times on `flags_q`. Stack memory, instruction decode and the check that enables the byte transfer lie outside this block.

Top module: `flag_reg_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads `flags_q` with 0x2 and clears `rd_valid` and `rd_data`.
- R2: Op code 1 sets carry (bit 0), op code 2 clears it, and op code 3 inverts it. No other bit changes.
- R3: Op codes 4 and 5 set and clear direction (bit 10). Op codes 6 and 7 set and clear interrupt enable (bit 9). No other bit changes.
- R4: Op code 8 (byte read) returns `rd_data` = {56'b0, f[7], f[6], 0, f[4], 0, f[2], 1, f[0]} with `rd_valid` high, and leaves `flags_q` unchanged.
- R5: Op code 9 (byte write) copies `wdata` bits 7, 6, 4, 2 and 0 into flag bits 7, 6, 4, 2 and 0. No other bit changes.
- R6: Op code 10 (push) with `op_wide`=0 returns the low 16 flag bits, zero-extended, with `rd_valid` high.
- R7: Op code 10 with `op_wide`=1 returns all 64 bits when `long_mode`=1 and the low 32 bits otherwise. In both cases bits 16 and 17 read as 0.
- R8: Op code 11 (pop) always writes bits 11, 10, 8, 7, 6, 4, 2 and 0 from `wdata`.
- R9: A pop writes bits 13:12 (I/O privilege field) only when `cpl` is 0. Otherwise they keep their value.
- R10: A pop writes bit 9 only when the I/O privilege field, as it stood before the pop, is numerically at least `cpl`. Otherwise bit 9 keeps its value.
- R11: A pop with `op_wide`=1 also writes bits 18 and 21. In either mode, bits 63:32 stay 0.
- R12: Bit 1 always reads 1. Bits 3, 5, 15 and 63:22 always read 0 and ignore writes.
- R13: `op_ready` is always 1. A cycle with `op_valid` low changes neither `flags_q` nor `rd_valid`, which stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_ready | output | 1 | Always 1 |
| op | input | 4 | Operation code |
| op_wide | input | 1 | 0: 16-bit push/pop, 1: wide |
| long_mode | input | 1 | Selects 64-bit wide push |
| cpl | input | 2 | Current privilege level |
| wdata | input | 64 | Pop or byte-write data |
| flags_q | output | 64 | Flags register |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 64 | Byte-read or push image |

## Verification
Every result is due one clock after the operation is accepted. `flags_q`, `rd_valid` and `rd_data` all change at the rising edge that samples `op_valid` high. Read images are formed from the flag value as it stood before that edge. The bench drives each operation at a falling edge, removes it at the next falling edge, and samples all outputs at that same point, when exactly one rising edge has passed. A bench model tracks the register across the full sweep of pop width, privilege level, prior I/O privilege field and data pattern.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FW = 64;
  localparam int CF_B = 0, PF_B = 2, AF_B = 4, ZF_B = 6, SF_B = 7;
  localparam int IF_B = 9, DF_B = 10;
  localparam int PL_LO = 12;
  localparam int RF_B = 16, VM_B = 17, AC_B = 18, ID_B = 21;
  localparam logic [FW-1:0] RESET_VAL = 64'h2;
  localparam logic [FW-1:0] IMPL_MASK = 64'h0000_0000_003F_7FD5;
  localparam logic [FW-1:0] POP_BASE  = 64'h0000_0000_0000_0DD5;
  localparam int NBYTE = 5;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_SETC = 4'd1, OP_CLRC = 4'd2, OP_INVC = 4'd3,
    OP_SETD = 4'd4, OP_CLRD = 4'd5, OP_SETI = 4'd6, OP_CLRI = 4'd7,
    OP_BRD = 4'd8, OP_BWR = 4'd9, OP_PUSH = 4'd10, OP_POP = 4'd11
  } flag_op_e;

  function automatic int byte_pos(input int i);
    case (i)
      0: return SF_B;
      1: return ZF_B;
      2: return AF_B;
      3: return PF_B;
      default: return CF_B;
    endcase
  endfunction
endpackage

// File: rtl/flag_pop_mask.sv
module flag_pop_mask
  import flag_pkg::*;
(
  input  logic          wide,
  input  logic [1:0]    cpl,
  input  logic [1:0]    iopl,
  output logic [FW-1:0] mask
);
  always_comb begin
    mask = POP_BASE;
    if (cpl == 2'd0) mask[PL_LO +: 2] = 2'b11;
    if (iopl >= cpl) mask[IF_B] = 1'b1;
    if (wide) begin
      mask[AC_B] = 1'b1;
      mask[ID_B] = 1'b1;
    end
  end
endmodule

// File: rtl/flag_update.sv
module flag_update
  import flag_pkg::*;
(
  input  logic [3:0]    op,
  input  logic          wide,
  input  logic          long_mode,
  input  logic [FW-1:0] cur,
  input  logic [FW-1:0] wdata,
  input  logic [FW-1:0] pop_mask,
  output logic [FW-1:0] nxt,
  output logic [FW-1:0] rimg,
  output logic          rfire
);
  logic [FW-1:0] byte_img, byte_nxt, push_img;

  always_comb begin
    byte_img = '0;
    byte_img[1] = 1'b1;
    byte_nxt = cur;
  end

  logic [NBYTE-1:0] bsel_rd, bsel_wr;
  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    localparam int P = byte_pos(i);
    assign bsel_rd[i] = cur[P];
    assign bsel_wr[i] = wdata[P];
  end

  logic [FW-1:0] br, bw;
  always_comb begin
    br = byte_img;
    bw = byte_nxt;
    for (int i = 0; i < NBYTE; i++) begin
      br[byte_pos(i)] = bsel_rd[i];
      bw[byte_pos(i)] = bsel_wr[i];
    end
  end

  always_comb begin
    push_img = cur;
    push_img[RF_B] = 1'b0;
    push_img[VM_B] = 1'b0;
    if (!wide) push_img = {48'b0, cur[15:0]};
    else if (!long_mode) push_img[FW-1:32] = '0;
  end

  always_comb begin
    nxt = cur;
    rimg = '0;
    rfire = 1'b0;
    case (flag_op_e'(op))
      OP_SETC: nxt[CF_B] = 1'b1;
      OP_CLRC: nxt[CF_B] = 1'b0;
      OP_INVC: nxt[CF_B] = ~cur[CF_B];
      OP_SETD: nxt[DF_B] = 1'b1;
      OP_CLRD: nxt[DF_B] = 1'b0;
      OP_SETI: nxt[IF_B] = 1'b1;
      OP_CLRI: nxt[IF_B] = 1'b0;
      OP_BRD: begin rimg = br; rfire = 1'b1; end
      OP_BWR: nxt = bw;
      OP_PUSH: begin rimg = push_img; rfire = 1'b1; end
      OP_POP: nxt = (cur & ~pop_mask) | (wdata & pop_mask);
      default: nxt = cur;
    endcase
    nxt = (nxt & IMPL_MASK) | RESET_VAL;
  end
endmodule

// File: rtl/flag_reg_unit.sv
module flag_reg_unit
  import flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [3:0]    op,
  input  logic          op_wide,
  input  logic          long_mode,
  input  logic [1:0]    cpl,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] flags_q,
  output logic          rd_valid,
  output logic [FW-1:0] rd_data
);
  logic [FW-1:0] mask, nxt, rimg;
  logic rfire;

  assign op_ready = 1'b1;

  flag_pop_mask u_mask (
    .wide(op_wide), .cpl(cpl), .iopl(flags_q[PL_LO +: 2]), .mask(mask)
  );

  flag_update u_upd (
    .op(op), .wide(op_wide), .long_mode(long_mode), .cur(flags_q),
    .wdata(wdata), .pop_mask(mask), .nxt(nxt), .rimg(rimg), .rfire(rfire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= RESET_VAL;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= op_valid && rfire;
      if (op_valid) begin
        flags_q <= nxt;
        if (rfire) rd_data <= rimg;
      end
    end
  end
endmodule

// File: rtl/flag_reg_chk.sv
module flag_reg_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic        op_ready,
  input logic [3:0]  op,
  input logic        op_wide,
  input logic [1:0]  cpl,
  input logic [63:0] flags_q,
  input logic        rd_valid,
  input logic [63:0] rd_data
);
  assert_fixed_bits_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (flags_q[1] && !flags_q[3] && !flags_q[5] && !flags_q[15] && flags_q[63:22] == '0));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(flags_q) && !rd_valid));

  assert_always_ready_R13: assert property (@(posedge clk) disable iff (rst) op_ready);

  assert_byte_read_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd8) |=> $stable(flags_q));

  assert_push_ctl_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd10 && op_wide) |=> (rd_valid && rd_data[17:16] == 2'b00));

  assert_iopl_guard_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd11 && cpl != 2'd0) |=> $stable(flags_q[13:12]));

  assert_if_guard_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd11 && cpl > flags_q[13:12]) |=> $stable(flags_q[9]));
endmodule

bind flag_reg_unit flag_reg_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready), .op(op),
  .op_wide(op_wide), .cpl(cpl), .flags_q(flags_q), .rd_valid(rd_valid),
  .rd_data(rd_data)
);

// File: tb/sim_flag_reg_unit.sv
`timescale 1ns/1ps
module sim_flag_reg_unit;
  logic clk = 1'b0, rst = 1'b1, op_valid = 1'b0, op_wide = 1'b0, long_mode = 1'b0;
  logic op_ready, rd_valid;
  logic [3:0] op = 4'd0;
  logic [1:0] cpl = 2'd0;
  logic [63:0] wdata = '0, flags_q, rd_data;
  logic [63:0] m;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [63:0] IMPL = 64'h3F7FD5;

  always #2 clk = ~clk;

  flag_reg_unit u0 (.clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op(op), .op_wide(op_wide), .long_mode(long_mode), .cpl(cpl), .wdata(wdata),
    .flags_q(flags_q), .rd_valid(rd_valid), .rd_data(rd_data));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic w, input logic lm,
                       input logic [1:0] c, input logic [63:0] d);
    @(negedge clk);
    op_valid = 1'b1; op = o; op_wide = w; long_mode = lm; cpl = c; wdata = d;
    @(negedge clk);
    op_valid = 1'b0; wdata = '0;
  endtask

  function automatic logic [63:0] pop_model(input logic [63:0] cur, input logic w,
                                            input logic [1:0] c, input logic [63:0] d);
    logic [63:0] mk;
    mk = 64'h0DD5;
    if (c == 0) mk |= 64'h3000;
    if (cur[13:12] >= c) mk |= 64'h200;
    if (w) mk |= (64'h1 << 18) | (64'h1 << 21);
    return (((cur & ~mk) | (d & mk)) & IMPL) | 64'h2;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset flags", flags_q, 64'h2);
    chk("R1 reset rd_valid", {63'b0, rd_valid}, 64'h0);
    m = 64'h2;

    do_op(4'd1, 0, 0, 0, 0); m[0] = 1; chk("R2 setc", flags_q, m);
    do_op(4'd3, 0, 0, 0, 0); m[0] = 0; chk("R2 invc", flags_q, m);
    do_op(4'd3, 0, 0, 0, 0); m[0] = 1; chk("R2 invc again", flags_q, m);
    do_op(4'd2, 0, 0, 0, 0); m[0] = 0; chk("R2 clrc", flags_q, m);
    do_op(4'd4, 0, 0, 0, 0); m[10] = 1; chk("R3 setd", flags_q, m);
    do_op(4'd6, 0, 0, 0, 0); m[9] = 1; chk("R3 seti", flags_q, m);
    do_op(4'd5, 0, 0, 0, 0); m[10] = 0; chk("R3 clrd", flags_q, m);
    do_op(4'd7, 0, 0, 0, 0); m[9] = 0; chk("R3 clri", flags_q, m);

    for (int p = 0; p < 32; p++) begin
      logic [63:0] d;
      d = {56'b0, p[4], p[3], 1'b1, p[2], 1'b1, p[1], 1'b0, p[0]} | 64'hFF00;
      do_op(4'd9, 0, 0, 3, d);
      m[7] = p[4]; m[6] = p[3]; m[4] = p[2]; m[2] = p[1]; m[0] = p[0];
      chk("R5 byte write", flags_q, m);
      do_op(4'd8, 0, 0, 3, '1);
      chk("R4 byte read", rd_data, {56'b0, m[7], m[6], 1'b0, m[4], 1'b0, m[2], 1'b1, m[0]});
      chk("R4 byte read valid", {63'b0, rd_valid}, 64'h1);
      chk("R4 flags kept", flags_q, m);
    end

    for (int pi = 0; pi < 4; pi++) begin
      logic [63:0] pat;
      case (pi)
        0: pat = '1;
        1: pat = '0;
        2: pat = 64'hAAAA_AAAA_AAAA_AAAA;
        default: pat = 64'h5555_5555_5555_5555;
      endcase
      for (int c = 0; c < 4; c++)
        for (int io = 0; io < 4; io++)
          for (int wm = 0; wm < 3; wm++) begin
            do_op(4'd11, 0, 0, 0, 64'(io) << 12);
            m = pop_model(m, 0, 0, 64'(io) << 12);
            chk("R9 seed iopl", flags_q, m);
            do_op(4'd11, wm != 0, wm == 2, 2'(c), pat);
            m = pop_model(m, wm != 0, 2'(c), pat);
            chk(wm != 0 ? "R11 wide pop" : (c == 0 ? "R9 pop" : "R10 pop"), flags_q, m);
            chk("R12 fixed bits", flags_q & ~IMPL, 64'h2);
            do_op(4'd10, 0, 0, 2'(c), 0);
            chk("R6 push16", rd_data, {48'b0, m[15:0]});
            do_op(4'd10, 1, 0, 2'(c), 0);
            chk("R7 push32", rd_data, {32'b0, m[31:0]} & ~64'h30000);
            do_op(4'd10, 1, 1, 2'(c), 0);
            chk("R7 push64", rd_data, m & ~64'h30000);
          end
    end

    do_op(4'd11, 0, 0, 0, 64'h0DD5);
    m = pop_model(m, 0, 0, 64'h0DD5);
    chk("R8 base pop", flags_q, m);

    @(negedge clk);
    op = 4'd3; wdata = '1; cpl = 0;
    @(negedge clk);
    chk("R13 idle no change", flags_q, m);
    chk("R13 idle no read", {63'b0, rd_valid}, 64'h0);
    chk("R13 ready", {63'b0, op_ready}, 64'h1);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule